// File: doc/BRIEF.md
# DIMM Population and Speed Validator

This block checks a memory population at power-up, before the DRAM controller is set up. Up to four module descriptors arrive one per clock on a valid-qualified port. Each descriptor gives the module's native data rate, the CL-tRCD-tRP timing sets it can run, device width, single- or double-sided build, device density, registered and ECC flags, and capacity. After the last slot, the block issues a one-cycle `done` strobe. With that strobe it gives either a 4-bit fault code or a resolved system data rate and timing triple. The rate is limited by the front-side-bus rate.

The controller is a three-state machine: `ST_COLLECT`, `ST_RESOLVE` and `ST_REPORT`. In `ST_COLLECT` it accepts descriptors and counts them. Accepting the last slot triggers *last-slot*, which moves it to `ST_RESOLVE`. From there it always takes *resolve-done* to `ST_REPORT`, where `done` is high. It then always takes *rearm* back to `ST_COLLECT`, and the accumulators are cleared. The results stay on the outputs until the next report.

Top module: `dimm_cfg_validator`

## Requirements
- R1: While reset is held and after it is released, `done`, `err_code`, `mem_rate` and the three timing outputs are all zero.
- R2: `done` is high for exactly one cycle, on the second clock edge after the edge that accepts the fourth descriptor. Cycles with `desc_valid` low are not counted as slots.
- R3: Field encodings are as follows.
  - `desc_rate`: 0 = 533, 1 = 667, 2 = 800, 3 = illegal.
  - `desc_tmask`: bit0 = 4-4-4, bit1 = 5-5-5, bit2 = 6-6-6.
  - `desc_width`: 0 = x4, 1 = x8, 2 = x16, 3 = x32.
  - `desc_density`: 0 = 64 Mb, 1 = 128 Mb, 2 = 256 Mb, 3 = 512 Mb, 4 = 1 Gb, 5 = 2 Gb, 6 = 4 Gb, 7 = reserved.
  - `desc_cap`: capacity in 128 MB units.
  - `fsb_rate`: 0 = 533, 1 = 800, 2 = 1066, 3 = illegal.
- R4: A populated module is rejected with these codes: illegal rate gives 1, density outside 256 Mb..1 Gb gives 2, x4 or x32 width gives 3, double-sided x16 gives 4, registered gives 5, ECC gives 6.
- R5: A populated module that does not list a legal timing for its own rate is rejected with code 7. The legal timings are 4-4-4 at 533, 5-5-5 at 667, and 5-5-5 or 6-6-6 at 800.
- R6: The reported fault is the first one found, in this order:
  - module faults, by lowest slot and then in the order of R4 and R5;
  - an illegal bus rate (11);
  - no memory (8);
  - too little memory (9);
  - no common timing (10).
- R7: A slot with zero capacity is skipped whatever its other fields hold. If all slots are empty, the code is 8.
- R8: A total capacity below 2 units (256 MB) gives code 9. Exactly 2 units is accepted.
- R9: The system rate is the lowest rate among populated modules. It is capped at 533 when the bus is 533, and at 800 for the other legal bus rates.
- R10: Every populated module must list the timing of the system rate. If any module does not, the code is 10.
- R11: At 800, 5-5-5 is chosen when every populated module lists it. Otherwise 6-6-6 is chosen when every populated module lists it.
- R12: On a fault, `mem_rate` and the timings read zero. On success, `err_code` is 0 and `t_cl`, `t_rcd` and `t_rp` all equal the chosen CL.
- R13: The outputs hold their values between `done` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsb_rate | input | 2 | Front-side-bus rate code |
| desc_valid | input | 1 | Descriptor valid |
| desc_rate | input | 2 | Native data rate code |
| desc_tmask | input | 3 | Offered timing sets |
| desc_width | input | 2 | Device width code |
| desc_dual | input | 1 | Double-sided module |
| desc_density | input | 3 | Device density code |
| desc_reg | input | 1 | Registered module |
| desc_ecc | input | 1 | Module carries ECC |
| desc_cap | input | 5 | Capacity in 128 MB units, 0 = empty slot |
| done | output | 1 | Result strobe |
| err_code | output | 4 | Fault code, 0 = accepted |
| mem_rate | output | 2 | Resolved data rate code |
| t_cl | output | 3 | Resolved CAS latency |
| t_rcd | output | 3 | Resolved RAS-to-CAS delay |
| t_rp | output | 3 | Resolved precharge time |

## Verification
The results register on the edge that leaves `ST_RESOLVE`, so they appear two edges after the fourth descriptor is accepted. The bench drives inputs on falling edges. On the falling edge right after the last accept, it checks that `done` is still low. On the next falling edge, it checks the strobe together with the code, rate and timings. On the falling edge after that, it checks that the strobe has dropped and that the values held. A sweep over two populated slots, with every rate and timing mask pair and every bus code, is compared against an arithmetic model in the bench.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
    typedef enum logic [1:0] {
        SPD_533  = 2'd0,
        SPD_667  = 2'd1,
        SPD_800  = 2'd2,
        SPD_NONE = 2'd3
    } spd_e;

    typedef enum logic [1:0] {
        BUS_533  = 2'd0,
        BUS_800  = 2'd1,
        BUS_1066 = 2'd2,
        BUS_BAD  = 2'd3
    } bus_e;

    typedef enum logic [3:0] {
        E_OK     = 4'd0,
        E_RATE   = 4'd1,
        E_DENS   = 4'd2,
        E_WIDTH  = 4'd3,
        E_X16DS  = 4'd4,
        E_REG    = 4'd5,
        E_ECC    = 4'd6,
        E_NATIVE = 4'd7,
        E_EMPTY  = 4'd8,
        E_SMALL  = 4'd9,
        E_SHIFT  = 4'd10,
        E_BUS    = 4'd11
    } fault_e;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_REPORT  = 2'd2
    } phase_e;

    localparam int TM_444 = 0;
    localparam int TM_555 = 1;
    localparam int TM_666 = 2;

    localparam logic [1:0] W_X4  = 2'd0;
    localparam logic [1:0] W_X16 = 2'd2;
    localparam logic [1:0] W_X32 = 2'd3;

    localparam logic [2:0] DEN_LO = 3'd2;
    localparam logic [2:0] DEN_HI = 3'd4;
endpackage

// File: rtl/dcv_desc_check.sv
module dcv_desc_check
    import dcv_pkg::*;
(
    input  logic [1:0] rate,
    input  logic [2:0] tmask,
    input  logic [1:0] width,
    input  logic       dual,
    input  logic [2:0] density,
    input  logic       regd,
    input  logic       ecc,
    output fault_e     fault
);
    logic native_ok;

    always_comb begin
        unique case (spd_e'(rate))
            SPD_533: native_ok = tmask[TM_444];
            SPD_667: native_ok = tmask[TM_555];
            SPD_800: native_ok = tmask[TM_555] | tmask[TM_666];
            default: native_ok = 1'b0;
        endcase
    end

    // R4/R5: per-module checks in fixed priority
    always_comb begin
        fault = E_OK;
        if (spd_e'(rate) == SPD_NONE)                  fault = E_RATE;
        else if (density < DEN_LO || density > DEN_HI) fault = E_DENS;
        else if (width == W_X4 || width == W_X32)      fault = E_WIDTH;
        else if (width == W_X16 && dual)               fault = E_X16DS;
        else if (regd)                                 fault = E_REG;
        else if (ecc)                                  fault = E_ECC;
        else if (!native_ok)                           fault = E_NATIVE;
    end
endmodule

// File: rtl/dcv_accum.sv
module dcv_accum
    import dcv_pkg::*;
#(
    parameter int CAP_W = 5,
    parameter int TOT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [CAP_W-1:0] cap,
    input  logic [1:0]       rate,
    input  logic [2:0]       tmask,
    input  fault_e           fault,
    output fault_e           first_fault,
    output logic             any_pop,
    output logic [TOT_W-1:0] total,
    output logic [1:0]       min_rate,
    output logic [2:0]       common
);
    logic populated;
    assign populated = (cap != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            first_fault <= E_OK;
            any_pop     <= 1'b0;
            total       <= '0;
            min_rate    <= 2'd3;
            common      <= 3'b111;
        end else if (take && populated) begin
            total   <= total + TOT_W'(cap);
            any_pop <= 1'b1;
            common  <= common & tmask;
            if (first_fault == E_OK) first_fault <= fault;
            if (rate < min_rate)     min_rate    <= rate;
        end
    end

    // R7: an empty slot leaves every accumulator untouched
    a_r7_empty_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear && cap == '0) |=> ($stable(total) && $stable(common) && $stable(first_fault)));

    // R6: once a module fault is latched it is not replaced within a pass
    a_r6_first_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (first_fault != E_OK && !clear) |=> first_fault == $past(first_fault));
endmodule

// File: rtl/dcv_resolve.sv
module dcv_resolve
    import dcv_pkg::*;
#(
    parameter int TOT_W     = 8,
    parameter int MIN_UNITS = 2
) (
    input  fault_e           first_fault,
    input  logic             any_pop,
    input  logic [TOT_W-1:0] total,
    input  logic [1:0]       min_rate,
    input  logic [2:0]       common,
    input  logic [1:0]       bus,
    output fault_e           fault,
    output logic [1:0]       rate,
    output logic [2:0]       cl
);
    logic [1:0] cap_rate;
    logic [1:0] sys_rate;

    assign cap_rate = (bus_e'(bus) == BUS_533) ? 2'(SPD_533) : 2'(SPD_800);
    assign sys_rate = (min_rate < cap_rate) ? min_rate : cap_rate;

    always_comb begin
        fault = first_fault;
        cl    = 3'd0;
        if (fault == E_OK) begin
            if (bus_e'(bus) == BUS_BAD)           fault = E_BUS;
            else if (!any_pop)                    fault = E_EMPTY;
            else if (total < TOT_W'(MIN_UNITS))   fault = E_SMALL;
            else begin
                unique case (spd_e'(sys_rate))
                    SPD_533: if (common[TM_444]) cl = 3'd4; else fault = E_SHIFT;
                    SPD_667: if (common[TM_555]) cl = 3'd5; else fault = E_SHIFT;
                    SPD_800: begin
                        if (common[TM_555])      cl = 3'd5;
                        else if (common[TM_666]) cl = 3'd6;
                        else                     fault = E_SHIFT;
                    end
                    default: fault = E_SHIFT;
                endcase
            end
        end
        if (fault != E_OK) cl = 3'd0;
        rate = (fault == E_OK) ? sys_rate : 2'd0;
    end
endmodule

// File: rtl/dimm_cfg_validator.sv
module dimm_cfg_validator
    import dcv_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CAP_W     = 5,
    parameter int MIN_UNITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fsb_rate,
    input  logic             desc_valid,
    input  logic [1:0]       desc_rate,
    input  logic [2:0]       desc_tmask,
    input  logic [1:0]       desc_width,
    input  logic             desc_dual,
    input  logic [2:0]       desc_density,
    input  logic             desc_reg,
    input  logic             desc_ecc,
    input  logic [CAP_W-1:0] desc_cap,
    output logic             done,
    output logic [3:0]       err_code,
    output logic [1:0]       mem_rate,
    output logic [2:0]       t_cl,
    output logic [2:0]       t_rcd,
    output logic [2:0]       t_rp
);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam int TOT_W = CAP_W + CNT_W;

    phase_e           state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             take, last;

    fault_e           mod_fault, acc_fault, res_fault;
    logic             acc_any;
    logic [TOT_W-1:0] acc_total;
    logic [1:0]       acc_min, res_rate;
    logic [2:0]       acc_common, res_cl;

    logic [3:0]       err_q;
    logic [1:0]       rate_q;
    logic [2:0]       cl_q;

    assign take = desc_valid && (state == ST_COLLECT);
    assign last = take && (cnt == CNT_W'(NUM_SLOTS - 1));

    dcv_desc_check u_check (
        .rate(desc_rate), .tmask(desc_tmask), .width(desc_width), .dual(desc_dual),
        .density(desc_density), .regd(desc_reg), .ecc(desc_ecc), .fault(mod_fault)
    );

    dcv_accum #(.CAP_W(CAP_W), .TOT_W(TOT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_REPORT), .take(take),
        .cap(desc_cap), .rate(desc_rate), .tmask(desc_tmask), .fault(mod_fault),
        .first_fault(acc_fault), .any_pop(acc_any), .total(acc_total),
        .min_rate(acc_min), .common(acc_common)
    );

    dcv_resolve #(.TOT_W(TOT_W), .MIN_UNITS(MIN_UNITS)) u_resolve (
        .first_fault(acc_fault), .any_pop(acc_any), .total(acc_total),
        .min_rate(acc_min), .common(acc_common), .bus(fsb_rate),
        .fault(res_fault), .rate(res_rate), .cl(res_cl)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= nxt;
    end

    // transitions: last-slot, resolve-done, rearm
    always_comb begin
        unique case (state)
            ST_COLLECT: nxt = last ? ST_RESOLVE : ST_COLLECT;
            ST_RESOLVE: nxt = ST_REPORT;
            ST_REPORT:  nxt = ST_COLLECT;
            default:    nxt = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (take) cnt <= last ? '0 : cnt + 1'b1;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            rate_q <= '0;
            cl_q   <= '0;
        end else if (state == ST_RESOLVE) begin
            err_q  <= res_fault;
            rate_q <= res_rate;
            cl_q   <= res_cl;
        end
    end

    assign done     = (state == ST_REPORT);
    assign err_code = err_q;
    assign mem_rate = rate_q;
    assign t_cl     = cl_q;
    assign t_rcd    = cl_q;
    assign t_rp     = cl_q;

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_due: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> ##1 done);

    a_r12_fault_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 4'd0) |-> (mem_rate == 2'd0 && t_cl == 3'd0));

    a_r12_ok_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 4'd0) |-> (t_cl >= 3'd4 && t_cl <= 3'd6 && mem_rate != 2'd3));

    a_r9_bus_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 4'd0 && fsb_rate == 2'd0) |-> mem_rate == 2'd0);

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(err_code) && $stable(mem_rate) && $stable(t_cl)));
endmodule

// File: tb/tb_dimm_cfg_validator.sv
module tb_dimm_cfg_validator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fsb_rate = '0;
    logic       desc_valid = 1'b0;
    logic [1:0] desc_rate = '0;
    logic [2:0] desc_tmask = '0;
    logic [1:0] desc_width = '0;
    logic       desc_dual = 1'b0;
    logic [2:0] desc_density = '0;
    logic       desc_reg = 1'b0;
    logic       desc_ecc = 1'b0;
    logic [4:0] desc_cap = '0;
    logic       done;
    logic [3:0] err_code;
    logic [1:0] mem_rate;
    logic [2:0] t_cl, t_rcd, t_rp;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int s_rate[4], s_mask[4], s_width[4], s_dual[4];
    int s_dens[4], s_reg[4], s_ecc[4], s_cap[4];
    int fsb = 2;
    bit gap = 0;

    always #2 clk = ~clk;

    dimm_cfg_validator dut (
        .clk(clk), .rst_n(rst_n), .fsb_rate(fsb_rate), .desc_valid(desc_valid),
        .desc_rate(desc_rate), .desc_tmask(desc_tmask), .desc_width(desc_width),
        .desc_dual(desc_dual), .desc_density(desc_density), .desc_reg(desc_reg),
        .desc_ecc(desc_ecc), .desc_cap(desc_cap), .done(done), .err_code(err_code),
        .mem_rate(mem_rate), .t_cl(t_cl), .t_rcd(t_rcd), .t_rp(t_rp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic slot_good(input int s);
        s_rate[s] = 2; s_mask[s] = 7; s_width[s] = 1; s_dual[s] = 0;
        s_dens[s] = 3; s_reg[s] = 0; s_ecc[s] = 0; s_cap[s] = 4;
    endtask

    task automatic all_good();
        for (int s = 0; s < 4; s++) slot_good(s);
        fsb = 2; gap = 0;
    endtask

    function automatic int mod_fault(input int s);
        bit nat;
        if (s_rate[s] == 3) return 1;
        if (s_dens[s] < 2 || s_dens[s] > 4) return 2;
        if (s_width[s] == 0 || s_width[s] == 3) return 3;
        if (s_width[s] == 2 && s_dual[s] != 0) return 4;
        if (s_reg[s] != 0) return 5;
        if (s_ecc[s] != 0) return 6;
        nat = (s_rate[s] == 0) ? s_mask[s][0] :
              (s_rate[s] == 1) ? s_mask[s][1] : (s_mask[s][1] | s_mask[s][2]);
        return nat ? 0 : 7;
    endfunction

    task automatic model(output int e, output int r, output int c);
        int tot = 0, minr = 3, common = 7;
        bit pop = 0;
        e = 0; r = 0; c = 0;
        for (int s = 0; s < 4; s++) begin
            if (s_cap[s] == 0) continue;
            pop = 1;
            tot += s_cap[s];
            if (e == 0) e = mod_fault(s);
            if (s_rate[s] < minr) minr = s_rate[s];
            common &= s_mask[s];
        end
        if (e == 0) begin
            if (fsb == 3) e = 11;
            else if (!pop) e = 8;
            else if (tot < 2) e = 9;
            else begin
                r = (fsb == 0) ? 0 : ((minr < 2) ? minr : 2);
                if (r == 0)      c = common[0] ? 4 : 0;
                else if (r == 1) c = common[1] ? 5 : 0;
                else             c = common[1] ? 5 : (common[2] ? 6 : 0);
                if (c == 0) e = 10;
            end
        end
        if (e != 0) begin r = 0; c = 0; end
    endtask

    task automatic run(input string req);
        int e, r, c;
        logic [3:0] he;
        logic [1:0] hr;
        logic [2:0] hc;
        model(e, r, c);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            fsb_rate = 2'(fsb);
            desc_valid = 1'b1;
            desc_rate = 2'(s_rate[s]); desc_tmask = 3'(s_mask[s]);
            desc_width = 2'(s_width[s]); desc_dual = s_dual[s][0];
            desc_density = 3'(s_dens[s]); desc_reg = s_reg[s][0];
            desc_ecc = s_ecc[s][0]; desc_cap = 5'(s_cap[s]);
            if (gap) begin
                @(negedge clk);
                desc_valid = 1'b0;
            end
        end
        if (!gap) begin
            @(negedge clk);
            desc_valid = 1'b0;
        end
        chk(done == 1'b0, "R2 early", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R2 strobe", int'(done), 1);
        chk(err_code == 4'(e), req, int'(err_code), e);
        chk(mem_rate == 2'(r), "R9 rate", int'(mem_rate), r);
        chk(t_cl == 3'(c) && t_rcd == 3'(c) && t_rp == 3'(c), "R12 timing", int'(t_cl), c);
        he = err_code; hr = mem_rate; hc = t_cl;
        @(negedge clk);
        chk(done == 1'b0 && err_code == he && mem_rate == hr && t_cl == hc,
            "R13 hold", int'(err_code), int'(he));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && err_code == 0 && mem_rate == 0 && t_cl == 0, "R1 in reset", int'(err_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && err_code == 0 && mem_rate == 0 && t_cl == 0 && t_rcd == 0 && t_rp == 0,
            "R1 after reset", int'(t_cl), 0);

        // R3/R4: one bad field each in slot 1
        all_good(); s_rate[1] = 3;  run("R4 rate");
        all_good(); s_dens[1] = 1;  run("R4 density 128Mb");
        all_good(); s_dens[1] = 5;  run("R4 density 2Gb");
        all_good(); s_width[1] = 0; run("R3 x4 width");
        all_good(); s_width[1] = 3; run("R4 x32 width");
        all_good(); s_width[1] = 2; s_dual[1] = 1; run("R4 x16 dual");
        all_good(); s_width[1] = 2; run("R4 x16 single ok");
        all_good(); s_reg[1] = 1;   run("R4 registered");
        all_good(); s_ecc[1] = 1;   run("R4 ecc");
        // R5
        all_good(); s_rate[0] = 0; s_mask[0] = 2; run("R5 native 533");
        all_good(); s_rate[2] = 2; s_mask[2] = 1; run("R5 native 800");
        // R6 ordering
        all_good(); s_ecc[1] = 1; s_reg[2] = 1; run("R6 lowest slot");
        all_good(); s_dens[0] = 0; s_ecc[0] = 1; run("R6 check order");
        all_good(); s_ecc[3] = 1; fsb = 3; run("R6 module over bus");
        all_good(); fsb = 3; run("R6 bad bus");
        // R7
        all_good(); for (int s = 0; s < 4; s++) s_cap[s] = 0; run("R7 all empty");
        all_good(); s_cap[2] = 0; s_ecc[2] = 1; s_rate[2] = 3; run("R7 empty skipped");
        // R8
        all_good(); for (int s = 1; s < 4; s++) s_cap[s] = 0; s_cap[0] = 1; run("R8 below minimum");
        all_good(); for (int s = 1; s < 4; s++) s_cap[s] = 0; s_cap[0] = 2; run("R8 at minimum");
        // R2 with idle gaps
        all_good(); gap = 1; s_rate[3] = 1; run("R2 gapped");

        // R9/R10/R11 sweep over two populated slots
        for (int ra = 0; ra < 3; ra++)
            for (int rb = 0; rb < 3; rb++)
                for (int ma = 0; ma < 8; ma++)
                    for (int mb = 0; mb < 8; mb++)
                        for (int f = 0; f < 4; f++) begin
                            all_good();
                            s_cap[2] = 0; s_cap[3] = 0;
                            s_rate[0] = ra; s_rate[1] = rb;
                            s_mask[0] = ma; s_mask[1] = mb;
                            fsb = f;
                            run("R10 R11 sweep");
                        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule